// File: doc/BRIEF.md
# Bit-Slice Median Engine

This block returns the median of a set of N unsigned W-bit integers without ever ordering them. A single-cycle start pulse captures the whole set from a flat input vector. The result is then built from its most significant end, B bits per clock. In each step the block looks only at the elements whose upper bits still agree with the partial result. It tallies those candidates per possible B-bit slice value, and it fixes the slice value that holds the target rank.

The target rank is (N-1)/2 with integer division, so an even-sized set yields its lower median. After W/B steps the result is complete. A done flag is raised, and both the flag and the result stay put until the next start. With the default of 16-bit data and 4-bit slices, one median costs four clocks, whatever the data.

Top module: `median_bitslice`

## Requirements
- R1: The set is taken from data_i (element k in bits k*W+W-1 down to k*W) on the clock edge where start_i is high. Changes to data_i on later edges have no effect on that run's result.
- R2: done_o goes high on the W/B-th rising edge after the edge that sampled start_i, and it stays low on the edges before it.
- R3: When done_o is high, median_o equals the element at index (N-1)/2 (counting from 0) of the set sorted in ascending order, which is the lower median for even N.
- R4: While done_o is high and start_i is low, done_o stays high and median_o stays unchanged from cycle to cycle.
- R5: A start_i pulse during a computation abandons it and starts afresh on the newly presented set, with the R2 timing counted from the new pulse.
- R6: While rst_ni is low, done_o is 0 and median_o is 0.
- R7: Sets with repeated values, including sets where every element is equal, give the R3 result.
- R8: On the edge after start_i is sampled, done_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Capture data_i and begin a median search |
| data_i | input | N*W | Packed input set, element k in bits k*W+W-1 down to k*W |
| done_o | output | 1 | Result valid, held until the next start |
| median_o | output | W | Median result |

## Verification
The assertions take for granted that N, W and B are set so that W is a multiple of B. They also assume that start_i is only ever a single-cycle request, sampled together with data_i. The bench drives start_i high for exactly one cycle in every case except the deliberate restart. It changes data_i between pulses to show that the captured copy is what counts. The random sets are drawn either from the full W-bit range or from a four-value range to force duplicates. Directed sets cover all-zero, all-ones, ordered and reversed data.

// File: rtl/median_pkg.sv
package median_pkg;
  function automatic int count_w(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  function automatic int idx_w(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/median_slice_count.sv
// Tallies candidates per slice value for the current step.
module median_slice_count
  import median_pkg::*;
#(
  parameter int N = 9,
  parameter int W = 16,
  parameter int B = 4,
  localparam int S  = W / B,
  localparam int NV = 1 << B,
  localparam int CW = count_w(N),
  localparam int SW = idx_w(S)
) (
  input  logic [N*W-1:0]   data_i,
  input  logic [W-1:0]     prefix_i,
  input  logic [SW-1:0]    step_i,
  output logic [NV*CW-1:0] cnt_o
);
  logic [N-1:0] cand;
  logic [B-1:0] slc [N];
  logic [W-1:0] umask;
  int unsigned  lo_idx;

  always_comb begin
    lo_idx = (S - 1 - int'(step_i)) * B;
    umask  = {W{1'b1}} << (lo_idx + B);
    for (int i = 0; i < N; i++) begin
      cand[i] = (((data_i[i*W +: W]) ^ prefix_i) & umask) == '0;
      slc[i]  = data_i[i*W + lo_idx +: B];
    end
  end

  for (genvar v = 0; v < NV; v++) begin : g_val
    logic [CW-1:0] acc;
    always_comb begin
      acc = '0;
      for (int i = 0; i < N; i++)
        if (cand[i] && slc[i] == B'(v)) acc = acc + CW'(1);
    end
    assign cnt_o[v*CW +: CW] = acc;
  end
endmodule

// File: rtl/median_slice_pick.sv
// Picks the first slice value whose running total passes the rank.
module median_slice_pick
  import median_pkg::*;
#(
  parameter int N = 9,
  parameter int B = 4,
  localparam int NV = 1 << B,
  localparam int CW = count_w(N)
) (
  input  logic [NV*CW-1:0] cnt_i,
  input  logic [CW-1:0]    rank_i,
  output logic [B-1:0]     sel_o,
  output logic [CW-1:0]    below_o
);
  logic [CW-1:0] run;
  logic [CW-1:0] nxt;
  logic          found;

  always_comb begin
    run     = '0;
    found   = 1'b0;
    sel_o   = B'(NV - 1);
    below_o = '0;
    for (int v = 0; v < NV; v++) begin
      nxt = run + cnt_i[v*CW +: CW];
      if (!found && nxt > rank_i) begin
        found   = 1'b1;
        sel_o   = B'(v);
        below_o = run;
      end
      run = nxt;
    end
  end
endmodule

// File: rtl/median_bitslice.sv
module median_bitslice
  import median_pkg::*;
#(
  parameter int N = 9,
  parameter int W = 16,
  parameter int B = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [N*W-1:0] data_i,
  output logic         done_o,
  output logic [W-1:0] median_o
);
  localparam int S    = W / B;
  localparam int NV   = 1 << B;
  localparam int CW   = count_w(N);
  localparam int SW   = idx_w(S);
  localparam int RANK = (N - 1) / 2;

  logic [N*W-1:0]   data_q;
  logic [W-1:0]     res_q;
  logic [CW-1:0]    rank_q;
  logic [SW-1:0]    step_q;
  logic             busy_q;
  logic             done_q;
  logic [NV*CW-1:0] cnt;
  logic [B-1:0]     sel;
  logic [CW-1:0]    below;
  int unsigned      lo_idx;

  median_slice_count #(.N(N), .W(W), .B(B)) u_count (
    .data_i   (data_q),
    .prefix_i (res_q),
    .step_i   (step_q),
    .cnt_o    (cnt)
  );

  median_slice_pick #(.N(N), .B(B)) u_pick (
    .cnt_i   (cnt),
    .rank_i  (rank_q),
    .sel_o   (sel),
    .below_o (below)
  );

  always_comb lo_idx = (S - 1 - int'(step_q)) * B;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      res_q  <= '0;
      rank_q <= '0;
      step_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (start_i) begin
      data_q <= data_i;
      res_q  <= '0;
      rank_q <= CW'(RANK);
      step_q <= '0;
      busy_q <= 1'b1;
      done_q <= 1'b0;
    end else if (busy_q) begin
      res_q[lo_idx +: B] <= sel;
      rank_q <= rank_q - below;
      if (step_q == SW'(S - 1)) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else begin
        step_q <= step_q + SW'(1);
      end
    end
  end

  assign done_o   = done_q;
  assign median_o = res_q;
endmodule

// File: rtl/median_bitslice_checker.sv
module median_bitslice_checker
  import median_pkg::*;
#(
  parameter int N = 9,
  parameter int W = 16,
  parameter int B = 4
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           start_i,
  input logic [N*W-1:0] data_i,
  input logic           done_o,
  input logic [W-1:0]   median_o
);
  localparam int S    = W / B;
  localparam int CW   = count_w(N);
  localparam int RANK = (N - 1) / 2;
  localparam int YW   = $clog2(S + 2);

  logic [N*W-1:0] cap_q;
  logic [YW-1:0]  cyc_q;
  logic [CW-1:0]  lt_cnt;
  logic [CW-1:0]  le_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q <= '0;
      cyc_q <= '0;
    end else if (start_i) begin
      cap_q <= data_i;
      cyc_q <= YW'(1);
    end else if (cyc_q != '0 && cyc_q != YW'(S + 1)) begin
      cyc_q <= cyc_q + YW'(1);
    end
  end

  always_comb begin
    lt_cnt = '0;
    le_cnt = '0;
    for (int i = 0; i < N; i++) begin
      if (cap_q[i*W +: W] <  median_o) lt_cnt = lt_cnt + CW'(1);
      if (cap_q[i*W +: W] <= median_o) le_cnt = le_cnt + CW'(1);
    end
  end

  a_r2_done_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> cyc_q == YW'(S + 1));

  a_r3_rank_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (lt_cnt <= CW'(RANK)) && (le_cnt > CW'(RANK)));

  a_r4_hold_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o && $stable(median_o));

  a_r8_start_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !done_o);
endmodule

bind median_bitslice median_bitslice_checker #(.N(N), .W(W), .B(B)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .data_i   (data_i),
  .done_o   (done_o),
  .median_o (median_o)
);

// File: tb/median_bitslice_bench.sv
module median_bitslice_bench;
  localparam int N = 9;
  localparam int W = 16;
  localparam int B = 4;
  localparam int S = W / B;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic           start_i = 1'b0;
  logic [N*W-1:0] data_i = '0;
  logic           done_o;
  logic [W-1:0]   median_o;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] vals [N];

  median_bitslice #(.N(N), .W(W), .B(B)) u_median_bitslice (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .data_i(data_i), .done_o(done_o), .median_o(median_o)
  );

  always #4 clk_i = ~clk_i;

  task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] ref_median();
    logic [W-1:0] s [N];
    logic [W-1:0] t;
    for (int i = 0; i < N; i++) s[i] = vals[i];
    for (int i = 1; i < N; i++)
      for (int j = i; j > 0 && s[j-1] > s[j]; j--) begin
        t = s[j]; s[j] = s[j-1]; s[j-1] = t;
      end
    return s[(N-1)/2];
  endfunction

  function automatic logic [N*W-1:0] pack();
    logic [N*W-1:0] p;
    for (int i = 0; i < N; i++) p[i*W +: W] = vals[i];
    return p;
  endfunction

  function automatic logic [N*W-1:0] junk();
    logic [N*W-1:0] p;
    for (int i = 0; i < N; i++) p[i*W +: W] = W'($urandom);
    return p;
  endfunction

  task automatic run_case(input string req);
    logic [W-1:0] exp;
    exp = ref_median();
    @(negedge clk_i);
    start_i = 1'b1;
    data_i  = pack();
    @(negedge clk_i);
    start_i = 1'b0;
    check(done_o == 1'b0, "R8", W'(done_o), '0);
    data_i = junk();  // R1: post-start changes must not matter
    repeat (S - 1) @(negedge clk_i);
    check(done_o == 1'b0, "R2 early", W'(done_o), '0);
    @(negedge clk_i);
    check(done_o == 1'b1, "R2", W'(done_o), W'(1));
    check(median_o == exp, req, median_o, exp);
    repeat (3) @(negedge clk_i);
    data_i = junk();
    check(done_o == 1'b1 && median_o == exp, "R4", median_o, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] exp;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk_i);
    check(done_o == 1'b0 && median_o == '0, "R6", median_o, '0);
    rst_ni = 1'b1;

    for (int i = 0; i < N; i++) vals[i] = '0;
    run_case("R7 all zero");
    for (int i = 0; i < N; i++) vals[i] = '1;
    run_case("R7 all ones");
    for (int i = 0; i < N; i++) vals[i] = W'(i * 1000);
    run_case("R3 ascending");
    for (int i = 0; i < N; i++) vals[i] = W'(16'hFFFF - i * 777);
    run_case("R3 descending");
    for (int i = 0; i < N; i++) vals[i] = (i < 5) ? 16'h1234 : 16'h1235;
    run_case("R7 near ties");
    for (int i = 0; i < N; i++) vals[i] = W'(i % 2 ? 16'hF000 : 16'h000F);
    run_case("R1 split slices");

    for (int k = 0; k < 40; k++) begin
      for (int i = 0; i < N; i++)
        vals[i] = (k % 2) ? W'($urandom % 4) : W'($urandom);
      run_case((k % 2) ? "R7 random dup" : "R3 random");
    end

    // R5: restart two cycles into a run
    for (int i = 0; i < N; i++) vals[i] = W'($urandom);
    @(negedge clk_i);
    start_i = 1'b1;
    data_i  = pack();
    @(negedge clk_i);
    start_i = 1'b0;
    @(negedge clk_i);
    for (int i = 0; i < N; i++) vals[i] = W'($urandom);
    exp = ref_median();
    start_i = 1'b1;
    data_i  = pack();
    @(negedge clk_i);
    start_i = 1'b0;
    data_i  = junk();
    repeat (S - 1) @(negedge clk_i);
    check(done_o == 1'b0, "R5 early", W'(done_o), '0);
    @(negedge clk_i);
    check(done_o == 1'b1 && median_o == exp, "R5", median_o, exp);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule